// File: doc/BRIEF.md
# Iterative Integer Multiply and Divide Unit

This block is a multi-cycle execution unit that performs the eight integer multiply, divide and remainder operations of a 32-bit RISC-V core's M extension. The issuing stage presents two operands and a 3-bit operation code through a valid/ready request port. The unit works on the operands without further input and returns a single 32-bit result through a valid/ready response port. It sits beside the main ALU. Decode, register access and hazard tracking stay with the surrounding pipeline.

Both multiply and divide work on operand magnitudes. The multiplier is a shift-add loop that builds a double-width product. The divider is a restoring loop that produces a quotient and a remainder. Both loops run one bit per clock. The result signs are applied when the loop ends. Division by zero and signed division by minus one need no loop: they complete on the accepting edge and give the defined non-trapping values. No exception is ever raised.

Top module: `muldiv_unit`

## Requirements
- R1: `reqReady` is high only while the unit is idle, with no operation running and no response pending. A request is taken on a clock edge where `reqValid` and `reqReady` are both high.
- R2: Once `rspValid` is high, it and `rspData` stay unchanged until an edge on which `rspReady` is high. The unit then returns to idle.
- R3: Code 000 returns the low 32 bits of the product of the two operands.
- R4: Codes 001, 010 and 011 return the high 32 bits of the 64-bit product. Code 001 treats both operands as signed. Code 010 treats A as signed and B as unsigned. Code 011 treats both as unsigned.
- R5: Code 100 (signed) and code 101 (unsigned) return the quotient A/B rounded toward zero.
- R6: Code 110 (signed) and code 111 (unsigned) return the remainder. A signed remainder takes the sign of the dividend.
- R7: When B is zero, codes 100 and 101 return all ones, and codes 110 and 111 return A unchanged.
- R8: When B is all ones, code 100 returns the two's-complement negation of A and code 110 returns zero. This includes A = 0x80000000, for which code 100 returns 0x80000000.
- R9: A division by zero, or a signed divide or remainder by all ones, shows `rspValid` right after the accepting edge. Every other operation shows `rspValid` exactly 32 clock edges after the accepting edge.
- R10: While reset is held low and just after it is released, `reqReady` is 1 and `rspValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Unit idle, request can be taken |
| reqFunct | input | 3 | Operation code (000 to 111 as listed in the requirements) |
| reqOpA | input | 32 | Operand A (multiplicand or dividend) |
| reqOpB | input | 32 | Operand B (multiplier or divisor) |
| rspValid | output | 1 | Result available |
| rspReady | input | 1 | Consumer takes the result |
| rspData | output | 32 | Result |

## Verification
The bound checker watches the handshake rules on every cycle: no request acceptance while a response is pending, a held result while backpressured, the single-cycle finish of the fast divide paths, and the exact 32-edge latency of the loops, which it measures with its own counter. It also checks the all-ones answer for unsigned division by zero. Whether the numeric results are right for each signedness variant can only be shown by the bench. The bench sends operand sweeps over zero, one, minus one and the extreme values, plus random pairs, and compares each result against a 64-bit arithmetic model, with random backpressure on the response.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [2:0] {
    FN_MUL    = 3'b000,
    FN_MULH   = 3'b001,
    FN_MULHSU = 3'b010,
    FN_MULHU  = 3'b011,
    FN_DIV    = 3'b100,
    FN_DIVU   = 3'b101,
    FN_REM    = 3'b110,
    FN_REMU   = 3'b111
  } mdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture operands, magnitudes and sign flags
    logic fastDone;  // write the no-loop divide result
    logic step;      // one loop iteration
    logic finish;    // last iteration: write signed result
  } mdStrobe_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int unsigned ITERS = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      rspReady,
  input  logic      isFast,
  output logic      reqReady,
  output logic      rspValid,
  output mdStrobe_t strobe
);

  localparam int unsigned CW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} ctrlState_e;

  ctrlState_e state;
  logic [CW-1:0] iterCnt;
  logic accept;
  logic lastIter;

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_DONE);
  assign accept   = reqValid & reqReady;
  assign lastIter = (state == ST_RUN) && (iterCnt == LAST);

  always_comb begin
    strobe          = '0;
    strobe.load     = accept;
    strobe.fastDone = accept & isFast;
    strobe.step     = (state == ST_RUN);
    strobe.finish   = lastIter;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            iterCnt <= '0;
            state   <= isFast ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (lastIter) state <= ST_DONE;
        end
        ST_DONE: begin
          if (rspReady) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdStrobe_t        strobe,
  input  mdOp_e            funct,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             isFast,
  output logic [WIDTH-1:0] result
);

  localparam int unsigned W2 = 2 * WIDTH;

  // ---------------- operand preparation ----------------
  logic isMulIn, aSigned, bSigned, aNeg, bNeg, bZero, bAllOnes;
  logic [WIDTH-1:0] aMag, bMag, fastRes;

  always_comb begin
    isMulIn  = ~funct[2];
    aSigned  = isMulIn ? (funct != FN_MULHU) : ~funct[0];
    bSigned  = isMulIn ? ~funct[1] : ~funct[0];
    aNeg     = aSigned & opA[WIDTH-1];
    bNeg     = bSigned & opB[WIDTH-1];
    aMag     = aNeg ? (~opA + 1'b1) : opA;
    bMag     = bNeg ? (~opB + 1'b1) : opB;
    bZero    = (opB == '0);
    bAllOnes = &opB;
    isFast   = funct[2] & (bZero | (~funct[0] & bAllOnes));
    if (bZero) fastRes = funct[1] ? opA : '1;
    else       fastRes = funct[1] ? '0 : (~opA + 1'b1);
  end

  // ---------------- iteration state ----------------
  mdOp_e            opReg;
  logic [WIDTH-1:0] hiReg, loReg, dReg, resReg;
  logic             negLo, negHi;

  // shift-add multiply step
  logic [WIDTH:0]   addSum;
  logic [WIDTH-1:0] mulHi, mulLo;
  // restoring divide step
  logic [WIDTH:0]   shifted;
  logic [WIDTH+1:0] trial;
  logic             fits;
  logic [WIDTH-1:0] divHi, divLo;
  logic [WIDTH-1:0] nextHi, nextLo;

  always_comb begin
    addSum  = {1'b0, hiReg} + (loReg[0] ? {1'b0, dReg} : '0);
    mulHi   = addSum[WIDTH:1];
    mulLo   = {addSum[0], loReg[WIDTH-1:1]};

    shifted = {hiReg, loReg[WIDTH-1]};
    trial   = {1'b0, shifted} - {2'b00, dReg};
    fits    = ~trial[WIDTH+1];
    divHi   = fits ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
    divLo   = {loReg[WIDTH-2:0], fits};

    nextHi  = opReg[2] ? divHi : mulHi;
    nextLo  = opReg[2] ? divLo : mulLo;
  end

  // ---------------- result formatting ----------------
  logic [W2-1:0]    prodRaw, prodSigned;
  logic [WIDTH-1:0] quo, rem, finalRes;

  always_comb begin
    prodRaw    = {nextHi, nextLo};
    prodSigned = negLo ? (~prodRaw + 1'b1) : prodRaw;
    quo        = negLo ? (~nextLo + 1'b1) : nextLo;
    rem        = negHi ? (~nextHi + 1'b1) : nextHi;
    if (!opReg[2])
      finalRes = (opReg == FN_MUL) ? prodSigned[WIDTH-1:0] : prodSigned[W2-1:WIDTH];
    else
      finalRes = opReg[1] ? rem : quo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg  <= FN_MUL;
      hiReg  <= '0;
      loReg  <= '0;
      dReg   <= '0;
      negLo  <= 1'b0;
      negHi  <= 1'b0;
      resReg <= '0;
    end else begin
      if (strobe.load) begin
        opReg <= funct;
        hiReg <= '0;
        loReg <= aMag;
        dReg  <= bMag;
        negLo <= aNeg ^ bNeg;
        negHi <= isMulIn ? (aNeg ^ bNeg) : aNeg;
      end else if (strobe.step) begin
        hiReg <= nextHi;
        loReg <= nextLo;
      end
      if (strobe.fastDone)    resReg <= fastRes;
      else if (strobe.finish) resReg <= finalRes;
    end
  end

  assign result = resReg;

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [2:0]       reqFunct,
  input  logic [WIDTH-1:0] reqOpA,
  input  logic [WIDTH-1:0] reqOpB,
  output logic             rspValid,
  input  logic             rspReady,
  output logic [WIDTH-1:0] rspData
);

  mdStrobe_t strobe;
  logic      isFast;

  muldiv_ctrl #(.ITERS(WIDTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rspReady (rspReady),
    .isFast   (isFast),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  muldiv_dp #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .funct  (mdOp_e'(reqFunct)),
    .opA    (reqOpA),
    .opB    (reqOpB),
    .isFast (isFast),
    .result (rspData)
  );

endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [2:0]       reqFunct,
  input logic [WIDTH-1:0] reqOpA,
  input logic [WIDTH-1:0] reqOpB,
  input logic             rspValid,
  input logic             rspReady,
  input logic [WIDTH-1:0] rspData
);

  localparam int unsigned LCW = $clog2(WIDTH) + 2;

  logic accepted, acceptFast;
  logic [LCW-1:0] latCnt;
  logic trackIter;

  assign accepted   = reqValid & reqReady;
  assign acceptFast = accepted & reqFunct[2] &
                      ((reqOpB == '0) | (~reqFunct[0] & (&reqOpB)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latCnt    <= '0;
      trackIter <= 1'b0;
    end else if (accepted) begin
      latCnt    <= '0;
      trackIter <= ~acceptFast;
    end else if (trackIter && !rspValid) begin
      latCnt    <= latCnt + 1'b1;
    end
  end

  assert_no_accept_pending_R1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> !reqReady);

  assert_hold_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData)));

  assert_divu_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqFunct == 3'b101 && reqOpB == '0) |=> (rspValid && rspData == '1));

  assert_fast_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    acceptFast |=> rspValid);

  assert_loop_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rspValid) && trackIter) |-> (latCnt == LCW'(WIDTH)));

endmodule

bind muldiv_unit muldiv_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqFunct (reqFunct),
  .reqOpA   (reqOpA),
  .reqOpB   (reqOpB),
  .rspValid (rspValid),
  .rspReady (rspReady),
  .rspData  (rspData)
);

// File: tb/test_muldiv_unit.sv
`timescale 1ns/1ps
module test_muldiv_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqFunct = '0;
  logic [31:0] reqOpA = '0;
  logic [31:0] reqOpB = '0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [31:0] rspData;

  always #2.5 clk = ~clk;  // 200 MHz

  muldiv_unit #(.WIDTH(32)) i_muldiv_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqFunct(reqFunct), .reqOpA(reqOpA), .reqOpB(reqOpB),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData)
  );

  typedef struct {
    logic [31:0] data;
    int          lat;
    int          acceptEdge;
    string       tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int  cycCnt = 0;
  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 1'b0;

  always @(posedge clk) cycCnt <= cycCnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural model on 64-bit arithmetic
  function automatic logic [31:0] refModel(logic [2:0] f, logic [31:0] a, logic [31:0] b);
    logic signed [63:0] sa, sb, ua, ub, p;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    ua = {32'b0, a};
    ub = {32'b0, b};
    case (f)
      3'd0: begin p = sa * sb; return p[31:0]; end
      3'd1: begin p = sa * sb; return p[63:32]; end
      3'd2: begin p = sa * ub; return p[63:32]; end
      3'd3: begin p = ua * ub; return p[63:32]; end
      3'd4: begin if (b == 0) return '1; p = sa / sb; return p[31:0]; end
      3'd5: begin if (b == 0) return '1; p = ua / ub; return p[31:0]; end
      3'd6: begin if (b == 0) return a;  p = sa % sb; return p[31:0]; end
      default: begin if (b == 0) return a; p = ua % ub; return p[31:0]; end
    endcase
  endfunction

  function automatic string reqTag(logic [2:0] f, logic [31:0] b);
    if (f[2] && b == 0) return "R7";
    if (f[2] && !f[0] && b == '1) return "R8";
    case (f)
      3'd0: return "R3";
      3'd1, 3'd2, 3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  // driver: offer one request and push its expectation
  task automatic sendOp(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    expItem_t it;
    @(negedge clk);
    reqValid = 1'b1; reqFunct = f; reqOpA = a; reqOpB = b;
    while (!reqReady) @(negedge clk);
    it.data       = refModel(f, a, b);
    it.lat        = (f[2] && (b == 0 || (!f[0] && b == '1))) ? 0 : 32;  // R9
    it.acceptEdge = cycCnt + 1;
    it.tag        = reqTag(f, b);
    scoreQ.push_back(it);
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  // monitor: pop and compare as results appear
  expItem_t cur;
  bit          haveCur = 1'b0;
  logic [31:0] prevData;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (rspValid) begin
        if (!haveCur) begin
          if (scoreQ.size() == 0) begin
            check(1'b0, "R1", "unexpected response", rspData, 32'h0);
          end else begin
            cur = scoreQ.pop_front();
            haveCur = 1'b1;
            check(cycCnt - cur.acceptEdge == cur.lat, "R9", "latency",
                  32'(cycCnt - cur.acceptEdge), 32'(cur.lat));
            check(rspData == cur.data, cur.tag, "result", rspData, cur.data);
          end
        end else begin
          check(rspData == prevData, "R2", "held result", rspData, prevData);
        end
        check(!reqReady, "R1", "ready while pending", 32'(reqReady), 32'h0);
        prevData = rspData;
        rspReady = ($urandom_range(2) != 0);
        if (rspReady) haveCur = 1'b0;
      end else begin
        rspReady = 1'b0;
      end
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R9 watchdog expired: actual %0d expected below 150000", cycCnt);
    summary();
    $finish;
  end

  logic [31:0] corners [6];

  initial begin
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'h7FFF_FFFF; corners[5] = 32'hFFFF_FFF9;

    repeat (3) @(negedge clk);
    // R10: state under reset
    check(reqReady == 1'b1, "R10", "reqReady in reset", 32'(reqReady), 32'h1);
    check(rspValid == 1'b0, "R10", "rspValid in reset", 32'(rspValid), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R10", "reqReady after reset", 32'(reqReady), 32'h1);
    check(rspValid == 1'b0, "R10", "rspValid after reset", 32'(rspValid), 32'h0);

    // directed: small values of both signs
    sendOp(3'd0, 32'd7, 32'd6);               // R3
    sendOp(3'd1, 32'hFFFF_FFF9, 32'd3);       // R4 signed high of -21
    sendOp(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R4 mixed signedness
    sendOp(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R4 unsigned
    sendOp(3'd4, 32'hFFFF_FFF9, 32'd2);       // R5 -7/2 = -3
    sendOp(3'd6, 32'hFFFF_FFF9, 32'd2);       // R6 -7%2 = -1
    sendOp(3'd4, 32'h8000_0000, 32'hFFFF_FFFF); // R8 overflow case
    sendOp(3'd6, 32'h8000_0000, 32'hFFFF_FFFF); // R8
    sendOp(3'd5, 32'd1234, 32'd0);            // R7
    sendOp(3'd7, 32'd1234, 32'd0);            // R7

    // sweep every code over the corner operands
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          sendOp(3'(f), corners[i], corners[j]);

    // random operands
    for (int k = 0; k < 120; k++)
      sendOp(3'($urandom_range(7)), $urandom, ($urandom_range(3) == 0) ? 32'($urandom_range(15)) : $urandom);

    while (scoreQ.size() != 0 || haveCur || rspValid) @(negedge clk);
    repeat (4) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule